// File: doc/BRIEF.md
# Microframe Index Counter Unit

This unit keeps the 14-bit microframe index of a USB host controller. Each microframe tick advances the index by one while the controller is running, and the index rolls over from 0x3FFF to 0. When wrap events are enabled, every rollover produces a one-clock wrap pulse for the event logic downstream.

To save power, the index pauses when no root-hub port needs it. Each port supplies a 3-bit link-state code. A port in one of the idle states does not need the index. The counter stops only when every port is idle. A U3-inclusion control decides whether a port in U3 counts as idle. While stopped, the index holds its value and later resumes from that value. A synchronous host-controller reset clears the index.

Top module: `mfidx_counter_top`

## Requirements
- R1: After the asynchronous reset, `index` is 0 and `wrap_pulse` is 0.
- R2: A clock with `mf_tick`=1 and `run`=1, while the stop condition is false, makes `index` one higher after that clock edge.
- R3: With `mf_tick`=0 or `run`=0, `index` keeps its value across the clock edge.
- R4: The index rolls over from 0x3FFF to 0x0000 on an advancing tick.
- R5: With `wrap_evt_en`=1, the advancing tick that makes `index` roll over to 0 raises `wrap_pulse`. The pulse appears in the same cycle in which `index` reads 0 and lasts exactly one clock.
- R6: With `wrap_evt_en`=0, a rollover still occurs but `wrap_pulse` stays 0.
- R7: Port state codes are 3 bits wide. Code 0 means disconnected, 1 disabled, 2 powered-off, 3 U0 and 4 U3. With `u3_idle_en`=0, the counter stops only when every port holds code 0, 1 or 2. A port in U3 (code 4) keeps the counter running.
- R8: With `u3_idle_en`=1, the counter stops when every port holds code 0, 1, 2 or 4.
- R9: Codes 3, 5, 6 and 7 always count as active, so a single port holding one of them keeps the counter running.
- R10: While stopped, `index` holds its value. Once the stop condition clears, counting resumes from the held value.
- R11: `hc_reset`=1 clears `index` to 0 and `wrap_pulse` to 0 at the next clock edge. It overrides a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hc_reset | input | 1 | Synchronous host-controller reset; clears the index |
| run | input | 1 | Controller running |
| mf_tick | input | 1 | One-clock microframe tick |
| wrap_evt_en | input | 1 | Enables wrap pulses |
| u3_idle_en | input | 1 | Counts U3 as an idle port state |
| port_state | input | NPORTS*3 | Link-state code per port; port p uses bits [3p+2:3p] |
| index | output | IDX_W | Current microframe index |
| wrap_pulse | output | 1 | One-clock wrap event |

## Verification
Both results are registered once. Inputs applied in cycle n therefore show up on `index` and `wrap_pulse` after the next rising edge. The stop decision is combinational from `port_state` and feeds that same edge. The bench drives every input on the falling edge and advances its own model once per step. It compares both outputs on the following falling edge, a full edge after the registers load. Directed runs to 0x3FFF with each setting of the wrap enable fix the exact cycle of the pulse. The bench also samples one cycle later to confirm that the pulse has dropped.

// File: rtl/mfidx_pkg.sv
package mfidx_pkg;
  localparam int PST_W = 3;

  typedef enum logic [PST_W-1:0] {
    PST_DISCON   = 3'd0,
    PST_DISABLED = 3'd1,
    PST_POWEROFF = 3'd2,
    PST_U0       = 3'd3,
    PST_U3       = 3'd4
  } pst_e;

  // Idle regardless of the U3 control.
  function automatic logic pst_base_idle(logic [PST_W-1:0] code);
    return (code == PST_DISCON) || (code == PST_DISABLED) || (code == PST_POWEROFF);
  endfunction

  function automatic logic pst_in_u3(logic [PST_W-1:0] code);
    return code == PST_U3;
  endfunction
endpackage

// File: rtl/mfidx_port_idle.sv
module mfidx_port_idle
  import mfidx_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic [NPORTS*PST_W-1:0] port_state,
  input  logic                    u3_idle_en,
  output logic [NPORTS-1:0]       base_vec,
  output logic [NPORTS-1:0]       u3_vec,
  output logic [NPORTS-1:0]       idle_vec
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [PST_W-1:0] code;
    assign code        = port_state[p*PST_W +: PST_W];
    assign base_vec[p] = pst_base_idle(code);
    assign u3_vec[p]   = pst_in_u3(code);
    assign idle_vec[p] = base_vec[p] | (u3_idle_en & u3_vec[p]);
  end
endmodule

// File: rtl/mfidx_stop_detect.sv
module mfidx_stop_detect #(
  parameter int NPORTS = 4
) (
  input  logic [NPORTS-1:0] idle_vec,
  output logic              all_idle
);
  assign all_idle = &idle_vec;
endmodule

// File: rtl/mfidx_index_reg.sv
module mfidx_index_reg #(
  parameter int IDX_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hc_reset,
  input  logic             adv,
  input  logic             wrap_evt_en,
  output logic [IDX_W-1:0] index,
  output logic             wrap_pulse,
  output logic             at_top
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  function automatic logic [IDX_W-1:0] idx_inc(logic [IDX_W-1:0] v);
    return (v == IDX_MAX) ? '0 : v + 1'b1;
  endfunction

  assign at_top = (index == IDX_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index      <= '0;
      wrap_pulse <= 1'b0;
    end else if (hc_reset) begin
      index      <= '0;
      wrap_pulse <= 1'b0;
    end else begin
      wrap_pulse <= adv & at_top & wrap_evt_en;
      if (adv) index <= idx_inc(index);
    end
  end

  // R2
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !hc_reset && !at_top) |=> (index == $past(index) + 1'b1));
  // R4
  rollover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !hc_reset && at_top) |=> (index == '0));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !hc_reset) |=> $stable(index));
  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |=> !wrap_pulse);
  // R5
  pulse_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> (index == '0));
  // R6
  pulse_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt_en |=> !wrap_pulse);
  // R11
  hcrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hc_reset |=> (index == '0 && !wrap_pulse));
endmodule

// File: rtl/mfidx_counter_top.sv
module mfidx_counter_top
  import mfidx_pkg::*;
#(
  parameter int IDX_W  = 14,
  parameter int NPORTS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hc_reset,
  input  logic                    run,
  input  logic                    mf_tick,
  input  logic                    wrap_evt_en,
  input  logic                    u3_idle_en,
  input  logic [NPORTS*PST_W-1:0] port_state,
  output logic [IDX_W-1:0]        index,
  output logic                    wrap_pulse
);
  logic [NPORTS-1:0] base_vec, u3_vec, idle_vec;
  logic              all_idle, adv, at_top;

  mfidx_port_idle #(.NPORTS(NPORTS)) u_idle (
    .port_state(port_state), .u3_idle_en(u3_idle_en),
    .base_vec(base_vec), .u3_vec(u3_vec), .idle_vec(idle_vec)
  );

  mfidx_stop_detect #(.NPORTS(NPORTS)) u_stop (
    .idle_vec(idle_vec), .all_idle(all_idle)
  );

  assign adv = mf_tick & run & ~all_idle;

  mfidx_index_reg #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .hc_reset(hc_reset), .adv(adv),
    .wrap_evt_en(wrap_evt_en), .index(index), .wrap_pulse(wrap_pulse),
    .at_top(at_top)
  );

  // R7
  u3_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!u3_idle_en && (|u3_vec)) |-> !all_idle);
  // R8
  u3_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u3_idle_en && (&(base_vec | u3_vec))) |-> all_idle);
  // R9
  active_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~base_vec & ~u3_vec)) |-> !all_idle);
  // R10
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (all_idle && !hc_reset) |=> $stable(index));
endmodule

// File: tb/mfidx_counter_top_bench.sv
module mfidx_counter_top_bench;
  localparam int IDX_W = 14;
  localparam int NP    = 4;
  localparam int MAXV  = (1 << IDX_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hc_reset = 0, run = 0, mf_tick = 0, wrap_evt_en = 0, u3_idle_en = 0;
  logic [NP*3-1:0] port_state = '0;
  logic [IDX_W-1:0] index;
  logic wrap_pulse;

  int checks = 0, bad = 0, cyc = 0;
  int exp_idx = 0;
  bit exp_pl = 0;

  always #2 clk = ~clk;

  mfidx_counter_top #(.IDX_W(IDX_W), .NPORTS(NP)) u_mfidx_counter_top (
    .clk(clk), .rst_n(rst_n), .hc_reset(hc_reset), .run(run), .mf_tick(mf_tick),
    .wrap_evt_en(wrap_evt_en), .u3_idle_en(u3_idle_en), .port_state(port_state),
    .index(index), .wrap_pulse(wrap_pulse)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++;
      $display("FAIL watchdog: got cycles=%0d exp <190000", cyc);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  function automatic bit b_idle(int code, bit u3en);
    if (code <= 2) return 1;
    if (code == 4 && u3en) return 1;
    return 0;
  endfunction

  function automatic bit b_stopped(logic [NP*3-1:0] ps, bit u3en);
    for (int p = 0; p < NP; p++)
      if (!b_idle(int'(ps[p*3 +: 3]), u3en)) return 0;
    return 1;
  endfunction

  function automatic logic [NP*3-1:0] all_ports(int code);
    logic [NP*3-1:0] v;
    for (int p = 0; p < NP; p++) v[p*3 +: 3] = 3'(code);
    return v;
  endfunction

  task automatic step(bit tk, bit rn, bit we, bit u3, logic [NP*3-1:0] ps, bit hr,
                      string tag);
    bit a;
    mf_tick = tk; run = rn; wrap_evt_en = we; u3_idle_en = u3;
    port_state = ps; hc_reset = hr;
    a = tk && rn && !b_stopped(ps, u3);
    if (hr) begin
      exp_idx = 0; exp_pl = 0;
    end else begin
      exp_pl = a && (exp_idx == MAXV) && we;
      if (a) exp_idx = (exp_idx == MAXV) ? 0 : exp_idx + 1;
    end
    @(negedge clk);
    checks++;
    if (int'(index) != exp_idx || wrap_pulse !== exp_pl) begin
      bad++;
      $display("FAIL %s: got idx=%h pulse=%b exp idx=%h pulse=%b",
               tag, index, wrap_pulse, exp_idx[IDX_W-1:0], exp_pl);
    end
  endtask

  task automatic run_to_top(bit we);
    while (exp_idx != MAXV) step(1, 1, we, 0, all_ports(3), 0, "R2");
  endtask

  initial begin
    logic [NP*3-1:0] ps;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    checks++;
    if (index !== '0 || wrap_pulse !== 1'b0) begin
      bad++;
      $display("FAIL R1: got idx=%h pulse=%b exp idx=0 pulse=0", index, wrap_pulse);
    end
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 1, 0, 0, all_ports(3), 0, "R1");
    repeat (5) step(1, 1, 0, 0, all_ports(3), 0, "R2");
    step(1, 0, 0, 0, all_ports(3), 0, "R3");
    step(0, 1, 0, 0, all_ports(3), 0, "R3");
    // R7: mix of idle codes, stopped
    step(1, 1, 0, 0, {3'd0, 3'd1, 3'd2, 3'd0}, 0, "R7");
    step(1, 1, 0, 0, {3'd2, 3'd1, 3'd2, 3'd0}, 0, "R10");
    step(1, 1, 0, 0, {3'd4, 3'd1, 3'd2, 3'd0}, 0, "R7");
    // R8: U3 counted idle
    step(1, 1, 0, 1, {3'd4, 3'd1, 3'd4, 3'd0}, 0, "R8");
    step(1, 1, 0, 1, all_ports(4), 0, "R8");
    // R9: active codes
    step(1, 1, 0, 1, {3'd5, 3'd0, 3'd0, 3'd0}, 0, "R9");
    step(1, 1, 0, 1, {3'd0, 3'd6, 3'd0, 3'd0}, 0, "R9");
    step(1, 1, 0, 1, {3'd0, 3'd0, 3'd7, 3'd0}, 0, "R9");
    step(1, 1, 0, 1, {3'd0, 3'd0, 3'd0, 3'd3}, 0, "R9");
    step(1, 1, 0, 0, all_ports(3), 0, "R10");
    // R11
    step(1, 1, 1, 0, all_ports(3), 1, "R11");
    step(1, 1, 1, 0, all_ports(3), 0, "R11");
    // R4/R5 wrap with event
    run_to_top(1);
    step(1, 1, 1, 0, all_ports(3), 0, "R5");
    step(0, 1, 1, 0, all_ports(3), 0, "R5");
    step(1, 1, 1, 0, all_ports(3), 0, "R4");
    // R6 wrap without event
    run_to_top(0);
    step(1, 1, 0, 0, all_ports(3), 0, "R6");
    step(1, 1, 0, 0, all_ports(3), 0, "R4");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit tk, rn, u3, hr;
      tk = ($urandom % 4) != 0;
      rn = ($urandom % 8) != 0;
      u3 = $urandom % 2;
      hr = ($urandom % 200) == 0;
      for (int p = 0; p < NP; p++)
        ps[p*3 +: 3] = ($urandom % 3 == 0) ? 3'($urandom % 8) :
                       (($urandom % 2) ? 3'd4 : 3'($urandom % 3));
      step(tk, rn, $urandom % 2, u3, ps, hr,
           hr ? "R11" : (!tk || !rn) ? "R3" : b_stopped(ps, u3) ? "R10" : "R2");
    end
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule